// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which frequency word drives the synthesizer of a digital phase-locked loop, and moves among three modes on its own: free-run, locked and holdover. An input selector supplies two flags: one saying that a reference has been validated, and one saying that the selected reference has failed. The loop supplies its current frequency-correction word together with a strobe that marks each loop update.

In free-run the block outputs a nominal word plus a calibration offset set by software. While locked, it passes the loop's word through. It also keeps an exponential moving average of that word, and the average becomes the holdover value. When the reference fails after the average has settled, the block freezes the average and drives the synthesizer from it. It stays in holdover until a new reference is validated. When it relocks, the output stays at the holdover value until the loop's first update, so the synthesizer sees no step. If the reference fails before the average has settled, the block drops back to free-run. A one-cycle pulse marks every mode change.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: During and after reset, mode reads 0 (free-run), modePulse is 0, holdReady is 0 and holdWord is 0.
- R2: In free-run (mode 0), freqWord equals the NOMINAL parameter plus calOffset, modulo 2^WORD_W.
- R3: A cycle with refValid high and refFail low, in free-run or holdover, makes mode read 1 (locked) from the next clock edge. refValid has no effect while locked.
- R4: In locked, the first loopStrobe after entry from free-run loads holdWord with loopWord. Each later loopStrobe sets holdWord to holdWord + ((loopWord - holdWord) >>> K), an arithmetic shift with both words signed. K is avgShift clamped to the range 4..16. The new value appears after that clock edge.
- R5: In locked, freqWord equals loopWord, except in the bridge window described in R7.
- R6: refFail in locked with holdReady high makes mode read 2 (holdover) from the next edge. In holdover, freqWord equals holdWord, and holdWord does not change. A loopStrobe in the failure cycle does not update the average.
- R7: On a return from holdover to locked, holdWord and the strobe count are kept. freqWord stays equal to holdWord until the first loopStrobe in locked, and follows loopWord from the cycle after it.
- R8: holdReady is high when the number of loopStrobes in locked since the last entry from free-run is at least 2^K. refFail in locked with holdReady low returns mode to 0 and restarts that count.
- R9: Holdover persists for any number of cycles, whatever loopStrobe and refFail do, until R3 applies. A cycle with refValid and refFail both high does not leave holdover.
- R10: modePulse is high for exactly the first cycle in which mode shows a new value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | Selector reports a validated reference |
| refFail | input | 1 | Selector reports failure of the selected reference |
| loopStrobe | input | 1 | One loop update of loopWord this cycle |
| loopWord | input | WORD_W | Loop frequency-correction word, signed |
| calOffset | input | WORD_W | Free-run calibration offset, signed |
| avgShift | input | 5 | Averaging shift K before clamping |
| mode | output | 2 | 0 free-run, 1 locked, 2 holdover |
| modePulse | output | 1 | One-cycle mode-change marker |
| freqWord | output | WORD_W | Word driving the synthesizer |
| holdWord | output | WORD_W | Stored long-term average |
| holdReady | output | 1 | Average has seen at least 2^K updates |

## Verification
Mode, modePulse and holdWord are registers, so each is due one clock edge after the input cycle that causes it. freqWord and holdReady are combinational from those registers and the current inputs, so they are due in the same cycle. The bench drives its inputs 1 ns after a rising edge and compares every output at the following falling edge against a behavioural model. The model updates at the rising edge from the inputs held across it, so every expected value lines up with the cycle in which the design's result is due.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_HOLD = 2'd2
  } opMode_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic avgUpdate;  // take loopWord into the average
    logic cntClear;   // restart the settling count
    logic bridgeSet;  // hold freqWord at the average after relock
    logic bridgeClr;  // release the bridge
  } ctrlStrobe_t;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refValid,
  input  logic        refFail,
  input  logic        loopStrobe,
  input  logic        holdReady,
  output opMode_t     mode,
  output logic        modePulse,
  output ctrlStrobe_t strobe
);
  opMode_t nextMode;
  logic    refGood;

  assign refGood = refValid && !refFail;

  always_comb begin
    nextMode = mode;
    strobe   = '0;
    unique case (mode)
      MODE_FREE: begin
        if (refGood) begin
          nextMode         = MODE_LOCK;
          strobe.cntClear  = 1'b1;
          strobe.bridgeClr = 1'b1;
        end
      end
      MODE_LOCK: begin
        if (refFail) begin
          strobe.bridgeClr = 1'b1;
          if (holdReady) begin
            nextMode = MODE_HOLD;
          end else begin
            nextMode        = MODE_FREE;
            strobe.cntClear = 1'b1;
          end
        end else if (loopStrobe) begin
          strobe.avgUpdate = 1'b1;
          strobe.bridgeClr = 1'b1;
        end
      end
      MODE_HOLD: begin
        if (refGood) begin
          nextMode         = MODE_LOCK;
          strobe.bridgeSet = 1'b1;
        end
      end
      default: nextMode = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_FREE;
      modePulse <= 1'b0;
    end else begin
      mode      <= nextMode;
      modePulse <= (nextMode != mode);
    end
  end

  a_r3_lock_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_LOCK && refValid && !refFail) |=> (mode == MODE_LOCK));
  a_r6_fail_leaves_lock: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCK && refFail) |=> (mode != MODE_LOCK));
  a_r9_hold_persists: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HOLD && !(refValid && !refFail)) |=> (mode == MODE_HOLD));
  a_r10_pulse_marks_change: assert property (@(posedge clk) disable iff (!rstN)
    modePulse == (mode != $past(mode)));
  a_r8_no_hold_unsettled: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCK && refFail && !holdReady) |=> (mode == MODE_FREE));
endmodule

// File: rtl/dpll_mode_dp.sv
module dpll_mode_dp
  import dpll_mode_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter logic signed [WORD_W-1:0] NOMINAL = '0,
  parameter int SHIFT_MIN = 4,
  parameter int SHIFT_MAX = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  opMode_t                  mode,
  input  ctrlStrobe_t              strobe,
  input  logic signed [WORD_W-1:0] loopWord,
  input  logic signed [WORD_W-1:0] calOffset,
  input  logic [4:0]               avgShift,
  output logic signed [WORD_W-1:0] freqWord,
  output logic signed [WORD_W-1:0] holdWord,
  output logic                     holdReady
);
  localparam int CNT_W = SHIFT_MAX + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(1) << SHIFT_MAX;

  logic signed [WORD_W-1:0] avgQ;
  logic [CNT_W-1:0]         cntQ;
  logic                     bridgeQ;
  logic [4:0]               shiftEff;
  logic signed [WORD_W:0]   diffW;
  logic signed [WORD_W:0]   stepW;
  logic [CNT_W-1:0]         threshold;

  always_comb begin
    if (avgShift < 5'(SHIFT_MIN))      shiftEff = 5'(SHIFT_MIN);
    else if (avgShift > 5'(SHIFT_MAX)) shiftEff = 5'(SHIFT_MAX);
    else                               shiftEff = avgShift;
  end

  assign diffW     = {loopWord[WORD_W-1], loopWord} - {avgQ[WORD_W-1], avgQ};
  assign stepW     = diffW >>> shiftEff;
  assign threshold = CNT_W'(1) << shiftEff;
  assign holdReady = (cntQ >= threshold);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      avgQ    <= '0;
      cntQ    <= '0;
      bridgeQ <= 1'b0;
    end else begin
      if (strobe.avgUpdate) begin
        if (cntQ == '0) avgQ <= loopWord;
        else            avgQ <= avgQ + stepW[WORD_W-1:0];
      end
      if (strobe.cntClear)                        cntQ <= '0;
      else if (strobe.avgUpdate && cntQ != CNT_SAT) cntQ <= cntQ + 1'b1;
      if (strobe.bridgeSet)      bridgeQ <= 1'b1;
      else if (strobe.bridgeClr) bridgeQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_LOCK: freqWord = bridgeQ ? avgQ : loopWord;
      MODE_HOLD: freqWord = avgQ;
      default:   freqWord = NOMINAL + calOffset;
    endcase
  end

  assign holdWord = avgQ;

  a_r6_avg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HOLD) |=> $stable(avgQ));
  a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_SAT);
  a_r7_bridge_only_locked: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeQ && mode == MODE_LOCK) |-> (freqWord == avgQ));
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter logic signed [WORD_W-1:0] NOMINAL = 32'sh1000_0000,
  parameter int SHIFT_MIN = 4,
  parameter int SHIFT_MAX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refValid,
  input  logic              refFail,
  input  logic              loopStrobe,
  input  logic [WORD_W-1:0] loopWord,
  input  logic [WORD_W-1:0] calOffset,
  input  logic [4:0]        avgShift,
  output logic [1:0]        mode,
  output logic              modePulse,
  output logic [WORD_W-1:0] freqWord,
  output logic [WORD_W-1:0] holdWord,
  output logic              holdReady
);
  opMode_t     modeQ;
  ctrlStrobe_t strobe;

  dpll_mode_fsm uFsm (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFail(refFail),
    .loopStrobe(loopStrobe), .holdReady(holdReady),
    .mode(modeQ), .modePulse(modePulse), .strobe(strobe)
  );

  dpll_mode_dp #(
    .WORD_W(WORD_W), .NOMINAL(NOMINAL),
    .SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX)
  ) uDp (
    .clk(clk), .rstN(rstN), .mode(modeQ), .strobe(strobe),
    .loopWord(loopWord), .calOffset(calOffset), .avgShift(avgShift),
    .freqWord(freqWord), .holdWord(holdWord), .holdReady(holdReady)
  );

  assign mode = modeQ;
endmodule

// File: tb/dpll_mode_ctrl_test.sv
module dpll_mode_ctrl_test;
  localparam int W = 32;
  localparam logic signed [W-1:0] NOM = 32'sh1000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refValid = 1'b0, refFail = 1'b0, loopStrobe = 1'b0;
  logic signed [W-1:0] loopWord = '0, calOffset = '0;
  logic [4:0] avgShift = 5'd4;
  logic [1:0] mode;
  logic modePulse, holdReady;
  logic [W-1:0] freqWord, holdWord;

  always #2 clk = ~clk;  // 250 MHz

  dpll_mode_ctrl uut (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFail(refFail),
    .loopStrobe(loopStrobe), .loopWord(loopWord), .calOffset(calOffset),
    .avgShift(avgShift), .mode(mode), .modePulse(modePulse),
    .freqWord(freqWord), .holdWord(holdWord), .holdReady(holdReady)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural model
  int mMode = 0;
  int mCnt = 0;
  bit mBridge = 0, mPulse = 0;
  logic signed [W-1:0] mAvg = '0;

  function automatic int kEff(input logic [4:0] s);
    if (s < 4) return 4;
    if (s > 16) return 16;
    return int'(s);
  endfunction

  always @(posedge clk) begin
    int k, prev;
    bit rdy;
    longint d;
    if (!rstN) begin
      mMode = 0; mCnt = 0; mBridge = 0; mPulse = 0; mAvg = '0;
    end else begin
      k = kEff(avgShift);
      rdy = (mCnt >= (1 << k));
      prev = mMode;
      if (mMode == 0) begin
        if (refValid && !refFail) begin mMode = 1; mCnt = 0; mBridge = 0; end
      end else if (mMode == 1) begin
        if (refFail) begin
          mBridge = 0;
          if (rdy) mMode = 2; else begin mMode = 0; mCnt = 0; end
        end else if (loopStrobe) begin
          if (mCnt == 0) mAvg = loopWord;
          else begin
            d = longint'(loopWord) - longint'(mAvg);
            mAvg = mAvg + W'(d >>> k);
          end
          if (mCnt < 65536) mCnt++;
          mBridge = 0;
        end
      end else begin
        if (refValid && !refFail) begin mMode = 1; mBridge = 1; end
      end
      mPulse = (prev != mMode);
    end
  end

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic signed [W-1:0] ef;
    if (rstN && !done) begin
      if (mMode == 0) ef = NOM + calOffset;
      else if (mMode == 1) ef = mBridge ? mAvg : loopWord;
      else ef = mAvg;
      cmp(mMode == 1 ? "R3" : (mMode == 2 ? "R9" : "R1"), "mode", longint'(mode), longint'(mMode));
      cmp("R10", "modePulse", longint'(modePulse), longint'(mPulse));
      cmp(mMode == 0 ? "R2" : (mMode == 2 ? "R6" : (mBridge ? "R7" : "R5")),
          "freqWord", longint'(freqWord), longint'(unsigned'(ef)));
      cmp("R4", "holdWord", longint'(holdWord), longint'(unsigned'(mAvg)));
      cmp("R8", "holdReady", longint'(holdReady), longint'(mCnt >= (1 << kEff(avgShift))));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobes(input int n, input int base, input int spread);
    for (int i = 0; i < n; i++) begin
      loopStrobe = 1'b1;
      loopWord = W'(base + int'($urandom_range(0, spread)) - spread / 2);
      step();
      loopStrobe = 1'b0;
      step();
    end
  endtask

  initial begin
    calOffset = 32'sd5;
    step(3);
    // R1: reset state (sampled while reset is held)
    @(negedge clk);
    cmp("R1", "reset mode", longint'(mode), 0);
    cmp("R1", "reset holdReady", longint'(holdReady), 0);
    cmp("R1", "reset holdWord", longint'(holdWord), 0);
    cmp("R2", "reset freqWord", longint'(freqWord), longint'(unsigned'(NOM + 32'sd5)));
    step();
    rstN = 1'b1;
    step(4);
    calOffset = -32'sd77;  // R2 with a negative offset
    step(3);
    // R3: lock, R8: unsettled failure returns to free-run
    refValid = 1'b1; step(); refValid = 1'b0;
    strobes(8, 1000, 40);
    refValid = 1'b1; step(2); refValid = 1'b0;  // R3: ignored while locked
    refFail = 1'b1; step(); refFail = 1'b0;
    step(3);
    // Relock and settle, then hold (R4, R6)
    refValid = 1'b1; step(); refValid = 1'b0;
    strobes(24, -5000, 400);
    loopStrobe = 1'b1; refFail = 1'b1; loopWord = 32'sd999999; step();  // R6 strobe ignored
    loopStrobe = 1'b0; refFail = 1'b0;
    // R9: holdover persists under strobes, failures, and valid+fail
    strobes(10, 7777, 10);
    refFail = 1'b1; step(5); refValid = 1'b1; step(3); refValid = 1'b0; refFail = 1'b0;
    step(200);
    // R7: relock with bridge, then first strobe releases it
    refValid = 1'b1; loopWord = 32'sd123456; step(); refValid = 1'b0;
    step(6);
    strobes(6, -4800, 100);
    refFail = 1'b1; step(); refFail = 1'b0;  // still settled: holdover again
    step(4);
    refValid = 1'b1; step(); refValid = 1'b0;
    strobes(3, 100, 10);
    // R4/R8: shift clamping and a longer window
    avgShift = 5'd1;  step(2);
    avgShift = 5'd20; step(2);
    avgShift = 5'd6;
    strobes(70, 300000, 5000);
    avgShift = 5'd8;
    strobes(10, 300000, 5000);
    refFail = 1'b1; step(); refFail = 1'b0;
    step(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule